// File: doc/BRIEF.md
# Pin Override Multiplexer for an 8-Bit General-Purpose Port

This block sits between the registers of an 8-bit general-purpose port and its pads. For every pin it takes the port data bit, the direction bit and a port-wide pull-up disable. From these it forms three pad controls: the drive value, the drive enable and the pull-up enable. On-chip peripherals can take over part of a pin. Each one does so through its own set of override enables and override values for the pull-up, the direction, the drive value and the digital-input gate. A peripheral therefore changes only the pad controls it needs and leaves the rest to the port registers.

The pins have fixed roles:

| Pin | Peripheral role |
|-----|-----------------|
| 0 | two-wire clock |
| 1 | two-wire data |
| 2 | serial receive |
| 3 | serial transmit |
| 4 | timer compare output |
| 5 | synchronous serial clock |
| 6 | external-memory address bit |
| 7 | divided system clock output |

Pins 0 to 3 also carry external-interrupt inputs.

Every pad input passes through a reset-cleared synchronizer before it reaches the port read path and the peripherals. The synchronizer has two flops by default. All pad controls are combinational from the inputs, and the synchronizer is the only state in the block.

Top module: `gpio_af_port`

## Requirements
- R1: With no override active on a pin, the drive value equals its port bit and the drive enable equals its direction bit. The pull-up is on exactly when the direction bit is 0, the port bit is 1 and `pu_dis` is 0.
- R2: `pin_sync` shows the gated pad input two clock edges after it is sampled, and it is 0 while `rst_n` is low.
- R3: While `tx_en` is 1, pin 3 is driven with `tx_data` and its drive enable is 1, whatever its direction bit. Its pull-up is off.
- R4: While `rx_en` is 1, pin 2 is not driven, whatever its direction bit. Its pull-up equals its port bit ANDed with the inverse of `pu_dis`.
- R5: While `twi_en` is 1, pins 0 and 1 act as open-drain pins. Their drive value is 0 and their drive enables equal `scl_drive_low` and `sda_drive_low`. Their pull-ups equal their port bits gated by the inverse of `pu_dis`.
- R6: While `in_gate_off` is 1, the synchronized input of every pin reads 0. The exception is a pin in 0..3 whose bit of `xint_en` is 1: that pin keeps passing its pad value.
- R7: Pin 6 is taken by the address override when `xmem_en` is 1 and `addr_mask` is below `ADDR_THRESH`, which defaults to 6. While taken, the pin drives `addr_bit`, its drive enable is 1 and its pull-up is off. When `addr_mask` is 6 or more, R1 applies.
- R8: On pin 5 the direction bit alone sets the drive enable. While `xck_en` is 1 and the direction bit is 1, the drive value is `xck_out`. Otherwise the drive value stays the port bit.
- R9: While `cmp_en` is 1, pin 4 drives `cmp_out` as its value. Its drive enable and pull-up still follow its direction bit and R1.
- R10: While `clko_en` is 1, pin 7 drives `clk_div` with its drive enable at 1 and its pull-up off, regardless of its port and direction bits. This also holds while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock for the input synchronizer |
| rst_n | input | 1 | asynchronous active-low reset of the synchronizer |
| port_q | input | 8 | port data bits |
| ddr_q | input | 8 | direction bits, 1 = drive |
| pu_dis | input | 1 | port-wide pull-up disable |
| in_gate_off | input | 1 | gates all digital inputs to 0 unless a pin's override keeps it |
| xint_en | input | 4 | external-interrupt enables for pins 0..3 |
| tx_en | input | 1 | serial transmitter enabled |
| tx_data | input | 1 | serial transmit bit |
| rx_en | input | 1 | serial receiver enabled |
| twi_en | input | 1 | two-wire interface enabled |
| scl_drive_low | input | 1 | two-wire clock pull-low request |
| sda_drive_low | input | 1 | two-wire data pull-low request |
| xck_en | input | 1 | synchronous clock mode active |
| xck_out | input | 1 | synchronous clock value to drive |
| cmp_en | input | 1 | timer compare output enabled |
| cmp_out | input | 1 | timer compare signal |
| xmem_en | input | 1 | external-memory interface enabled |
| addr_mask | input | 3 | address-mask setting |
| addr_bit | input | 1 | address bit for pin 6 |
| clko_en | input | 1 | divided-clock output configuration bit |
| clk_div | input | 1 | divided system clock |
| pad_in | input | 8 | raw pad input values |
| pad_out | output | 8 | pad drive values |
| pad_oe | output | 8 | pad drive enables |
| pad_pu | output | 8 | pad pull-up enables |
| pin_sync | output | 8 | synchronized, gated pin inputs |

## Verification
The properties assume that every input changes between clock edges and that no input is X once reset is released. The synchronizer property also assumes that `in_gate_off` and `pad_in` change only between edges, so that a value sampled two edges earlier can be compared with `pin_sync`. The bench drives all inputs on the falling edge and samples shortly afterwards. It holds the pad inputs steady for several edges before each synchronizer check.

// File: rtl/gpio_af_pkg.sv
package gpio_af_pkg;
  localparam int NPIN   = 8;
  localparam int NXINT  = 4;
  localparam int PIN_SCL = 0;
  localparam int PIN_SDA = 1;
  localparam int PIN_RXD = 2;
  localparam int PIN_TXD = 3;
  localparam int PIN_CMP = 4;
  localparam int PIN_XCK = 5;
  localparam int PIN_ADR = 6;
  localparam int PIN_CKO = 7;

  // one override bundle per pin: enable/value pairs
  typedef struct packed {
    logic pu_en;
    logic pu_val;
    logic dir_en;
    logic dir_val;
    logic val_en;
    logic val_val;
    logic die_en;
    logic die_val;
  } ovr_t;
endpackage

// File: rtl/gpio_af_map.sv
module gpio_af_map
  import gpio_af_pkg::*;
#(
  parameter int MASK_W      = 3,
  parameter int ADDR_THRESH = 6
) (
  input  logic [NPIN-1:0]  port_q,
  input  logic [NPIN-1:0]  ddr_q,
  input  logic             pu_dis,
  input  logic [NXINT-1:0] xint_en,
  input  logic             tx_en,
  input  logic             tx_data,
  input  logic             rx_en,
  input  logic             twi_en,
  input  logic             scl_drive_low,
  input  logic             sda_drive_low,
  input  logic             xck_en,
  input  logic             xck_out,
  input  logic             cmp_en,
  input  logic             cmp_out,
  input  logic             xmem_en,
  input  logic [MASK_W-1:0] addr_mask,
  input  logic             addr_bit,
  input  logic             clko_en,
  input  logic             clk_div,
  output ovr_t [NPIN-1:0]  ovr
);
  localparam logic [MASK_W:0] THR = (MASK_W+1)'(ADDR_THRESH);

  logic adr_take;
  logic xck_drive;

  assign adr_take  = xmem_en & ({1'b0, addr_mask} < THR);
  assign xck_drive = xck_en & ddr_q[PIN_XCK];

  always_comb begin
    ovr = '0;
    // external interrupts keep their pins sensed
    for (int i = 0; i < NXINT; i++) begin
      ovr[i].die_en  = xint_en[i];
      ovr[i].die_val = 1'b1;
    end
    // two-wire pair: open-drain emulation
    if (twi_en) begin
      ovr[PIN_SCL].pu_en   = 1'b1;
      ovr[PIN_SCL].pu_val  = port_q[PIN_SCL] & ~pu_dis;
      ovr[PIN_SCL].dir_en  = 1'b1;
      ovr[PIN_SCL].dir_val = scl_drive_low;
      ovr[PIN_SCL].val_en  = 1'b1;
      ovr[PIN_SCL].val_val = 1'b0;
      ovr[PIN_SDA].pu_en   = 1'b1;
      ovr[PIN_SDA].pu_val  = port_q[PIN_SDA] & ~pu_dis;
      ovr[PIN_SDA].dir_en  = 1'b1;
      ovr[PIN_SDA].dir_val = sda_drive_low;
      ovr[PIN_SDA].val_en  = 1'b1;
      ovr[PIN_SDA].val_val = 1'b0;
    end
    // serial receive: forced input, pull-up kept under port control
    if (rx_en) begin
      ovr[PIN_RXD].pu_en   = 1'b1;
      ovr[PIN_RXD].pu_val  = port_q[PIN_RXD] & ~pu_dis;
      ovr[PIN_RXD].dir_en  = 1'b1;
      ovr[PIN_RXD].dir_val = 1'b0;
    end
    // serial transmit: forced output with data
    if (tx_en) begin
      ovr[PIN_TXD].pu_en   = 1'b1;
      ovr[PIN_TXD].pu_val  = 1'b0;
      ovr[PIN_TXD].dir_en  = 1'b1;
      ovr[PIN_TXD].dir_val = 1'b1;
      ovr[PIN_TXD].val_en  = 1'b1;
      ovr[PIN_TXD].val_val = tx_data;
    end
    // timer compare: value only
    ovr[PIN_CMP].val_en  = cmp_en;
    ovr[PIN_CMP].val_val = cmp_out;
    // synchronous clock: value only when the direction says drive
    ovr[PIN_XCK].val_en  = xck_drive;
    ovr[PIN_XCK].val_val = xck_out;
    // address bit
    if (adr_take) begin
      ovr[PIN_ADR].pu_en   = 1'b1;
      ovr[PIN_ADR].pu_val  = 1'b0;
      ovr[PIN_ADR].dir_en  = 1'b1;
      ovr[PIN_ADR].dir_val = 1'b1;
      ovr[PIN_ADR].val_en  = 1'b1;
      ovr[PIN_ADR].val_val = addr_bit;
    end
    // divided clock output, independent of reset
    if (clko_en) begin
      ovr[PIN_CKO].pu_en   = 1'b1;
      ovr[PIN_CKO].pu_val  = 1'b0;
      ovr[PIN_CKO].dir_en  = 1'b1;
      ovr[PIN_CKO].dir_val = 1'b1;
      ovr[PIN_CKO].val_en  = 1'b1;
      ovr[PIN_CKO].val_val = clk_div;
    end
  end
endmodule

// File: rtl/gpio_af_cell.sv
module gpio_af_cell
  import gpio_af_pkg::*;
(
  input  logic port_b,
  input  logic dir_b,
  input  logic pu_dis,
  input  logic gate_off,
  input  ovr_t ovr,
  output logic pad_o,
  output logic pad_en,
  output logic pull_en,
  output logic din_en
);
  logic pull_base;

  assign pull_base = ~dir_b & port_b & ~pu_dis;
  assign pull_en   = ovr.pu_en  ? ovr.pu_val  : pull_base;
  assign pad_en    = ovr.dir_en ? ovr.dir_val : dir_b;
  assign pad_o     = ovr.val_en ? ovr.val_val : port_b;
  assign din_en    = ovr.die_en ? ovr.die_val : ~gate_off;
endmodule

// File: rtl/gpio_af_sync.sv
module gpio_af_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_af_port.sv
module gpio_af_port
  import gpio_af_pkg::*;
#(
  parameter int MASK_W      = 3,
  parameter int ADDR_THRESH = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   port_q,
  input  logic [NPIN-1:0]   ddr_q,
  input  logic              pu_dis,
  input  logic              in_gate_off,
  input  logic [NXINT-1:0]  xint_en,
  input  logic              tx_en,
  input  logic              tx_data,
  input  logic              rx_en,
  input  logic              twi_en,
  input  logic              scl_drive_low,
  input  logic              sda_drive_low,
  input  logic              xck_en,
  input  logic              xck_out,
  input  logic              cmp_en,
  input  logic              cmp_out,
  input  logic              xmem_en,
  input  logic [MASK_W-1:0] addr_mask,
  input  logic              addr_bit,
  input  logic              clko_en,
  input  logic              clk_div,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_pu,
  output logic [NPIN-1:0]   pin_sync
);
  ovr_t [NPIN-1:0] ovr;
  logic [NPIN-1:0] din_en;

  gpio_af_map #(.MASK_W(MASK_W), .ADDR_THRESH(ADDR_THRESH)) u_map (
    .port_q(port_q), .ddr_q(ddr_q), .pu_dis(pu_dis), .xint_en(xint_en),
    .tx_en(tx_en), .tx_data(tx_data), .rx_en(rx_en), .twi_en(twi_en),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .xck_en(xck_en), .xck_out(xck_out), .cmp_en(cmp_en), .cmp_out(cmp_out),
    .xmem_en(xmem_en), .addr_mask(addr_mask), .addr_bit(addr_bit),
    .clko_en(clko_en), .clk_div(clk_div), .ovr(ovr)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gpio_af_cell u_cell (
      .port_b  (port_q[i]),
      .dir_b   (ddr_q[i]),
      .pu_dis  (pu_dis),
      .gate_off(in_gate_off),
      .ovr     (ovr[i]),
      .pad_o   (pad_out[i]),
      .pad_en  (pad_oe[i]),
      .pull_en (pad_pu[i]),
      .din_en  (din_en[i])
    );
  end

  gpio_af_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in & din_en), .q(pin_sync)
  );
endmodule

// File: rtl/gpio_af_port_chk.sv
module gpio_af_port_chk
  import gpio_af_pkg::*;
#(
  parameter int MASK_W      = 3,
  parameter int ADDR_THRESH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPIN-1:0]   port_q,
  input logic [NPIN-1:0]   ddr_q,
  input logic              pu_dis,
  input logic              in_gate_off,
  input logic [NXINT-1:0]  xint_en,
  input logic              tx_en,
  input logic              tx_data,
  input logic              rx_en,
  input logic              twi_en,
  input logic              scl_drive_low,
  input logic              xck_en,
  input logic              xck_out,
  input logic              cmp_en,
  input logic              cmp_out,
  input logic              xmem_en,
  input logic [MASK_W-1:0] addr_mask,
  input logic              addr_bit,
  input logic              clko_en,
  input logic              clk_div,
  input logic [NPIN-1:0]   pad_in,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   pad_pu,
  input logic [NPIN-1:0]   pin_sync
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1: pin 4 without compare override follows port registers
  p_plain_pin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |-> (pad_out[4] == port_q[4]) && (pad_oe[4] == ddr_q[4]) &&
                (pad_pu[4] == (!ddr_q[4] && port_q[4] && !pu_dis)));

  // R2: two-edge latency on an ungated pin
  p_sync_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> pin_sync[4] == ($past(pad_in[4], 2) && !$past(in_gate_off, 2)));

  // R3
  p_tx_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> pad_oe[3] && (pad_out[3] == tx_data) && !pad_pu[3]);

  // R4
  p_rx_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |-> !pad_oe[2] && (pad_pu[2] == (port_q[2] && !pu_dis)));

  // R5
  p_twi_od_r5: assert property (@(posedge clk) disable iff (!rst_n)
    twi_en |-> !pad_out[0] && !pad_out[1] && (pad_oe[0] == scl_drive_low));

  // R6: an interrupt-enabled pin stays sensed
  p_xint_sense_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) && $past(xint_en[0], 2) |-> pin_sync[0] == $past(pad_in[0], 2));

  // R7
  p_addr_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xmem_en && (int'(addr_mask) < ADDR_THRESH) |-> pad_oe[6] && (pad_out[6] == addr_bit) && !pad_pu[6]);

  // R8
  p_xck_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[5] == ddr_q[5]);
  p_xck_val_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xck_en && ddr_q[5] |-> pad_out[5] == xck_out);

  // R9
  p_cmp_val_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |-> (pad_out[4] == cmp_out) && (pad_oe[4] == ddr_q[4]));

  // R10
  p_clko_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clko_en |-> pad_oe[7] && (pad_out[7] == clk_div) && !pad_pu[7]);
endmodule

bind gpio_af_port gpio_af_port_chk #(.MASK_W(MASK_W), .ADDR_THRESH(ADDR_THRESH)) u_chk (.*);

// File: tb/test_gpio_af_port.sv
module test_gpio_af_port;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] port_q = '0, ddr_q = '0, pad_in = '0;
  logic pu_dis = 0, in_gate_off = 0;
  logic [3:0] xint_en = '0;
  logic tx_en = 0, tx_data = 0, rx_en = 0, twi_en = 0, scl_drive_low = 0, sda_drive_low = 0;
  logic xck_en = 0, xck_out = 0, cmp_en = 0, cmp_out = 0, xmem_en = 0, addr_bit = 0;
  logic [2:0] addr_mask = '0;
  logic clko_en = 0, clk_div = 0;
  logic [7:0] pad_out, pad_oe, pad_pu, pin_sync;

  int total = 0;
  int bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  gpio_af_port i_gpio_af_port (
    .clk(clk), .rst_n(rst_n), .port_q(port_q), .ddr_q(ddr_q), .pu_dis(pu_dis),
    .in_gate_off(in_gate_off), .xint_en(xint_en), .tx_en(tx_en), .tx_data(tx_data),
    .rx_en(rx_en), .twi_en(twi_en), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .xck_en(xck_en), .xck_out(xck_out),
    .cmp_en(cmp_en), .cmp_out(cmp_out), .xmem_en(xmem_en), .addr_mask(addr_mask),
    .addr_bit(addr_bit), .clko_en(clko_en), .clk_div(clk_div), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pin_sync(pin_sync)
  );

  // field order: port ddr pu_dis tx_en tx_d rx_en twi scl_lo sda_lo xck_en xck_o
  //              cmp_en cmp_o xmem mask adr_b clko cdiv | exp_out exp_oe exp_pu
  typedef struct packed {
    logic [7:0] port; logic [7:0] ddr;
    logic pud; logic txe; logic txd; logic rxe; logic twe; logic scl; logic sda;
    logic xce; logic xco; logic cme; logic cmo; logic xme; logic [2:0] msk;
    logic adb; logic cke; logic ckd;
    logic [7:0] e_out; logic [7:0] e_oe; logic [7:0] e_pu;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{8'hFF,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'hFF,8'h00,8'hFF},
    '{8'hFF,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'hFF,8'h00,8'h00},
    '{8'h0F,8'hF0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'h0F,8'hF0,8'h0F},
    '{8'h00,8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'h08,8'h08,8'h00},
    '{8'h04,8'h04,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'h04,8'h00,8'h04},
    '{8'h03,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'h00,8'h01,8'h03},
    '{8'h03,8'h03,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'h00,8'h02,8'h00},
    '{8'h40,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd5,1'b1,1'b0,1'b0, 8'h40,8'h40,8'h00},
    '{8'h40,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd6,1'b0,1'b0,1'b0, 8'h40,8'h00,8'h40},
    '{8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd7,1'b1,1'b0,1'b0, 8'h00,8'h00,8'h00},
    '{8'h00,8'h20,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'h20,8'h20,8'h00},
    '{8'h20,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'h20,8'h00,8'h20},
    '{8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,3'd0,1'b0,1'b0,1'b0, 8'h10,8'h00,8'h00},
    '{8'h10,8'h10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'h00,8'h10,8'h00},
    '{8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b1,1'b1, 8'h80,8'h80,8'h00},
    '{8'h80,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b1,1'b0, 8'h00,8'h80,8'h00}
  };
  // tags per row: R1 R1 R1 R3 R4 R5 R5 R7 R7 R7 R8 R8 R9 R9 R10 R10

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    port_q = v.port; ddr_q = v.ddr; pu_dis = v.pud;
    tx_en = v.txe; tx_data = v.txd; rx_en = v.rxe; twi_en = v.twe;
    scl_drive_low = v.scl; sda_drive_low = v.sda; xck_en = v.xce; xck_out = v.xco;
    cmp_en = v.cme; cmp_out = v.cmo; xmem_en = v.xme; addr_mask = v.msk;
    addr_bit = v.adb; clko_en = v.cke; clk_div = v.ckd;
  endtask

  // reference model written from R1, R3..R5, R7..R10
  function automatic vec_t model(input vec_t v);
    vec_t r = v;
    for (int i = 0; i < 8; i++) begin
      r.e_out[i] = v.port[i];
      r.e_oe[i]  = v.ddr[i];
      r.e_pu[i]  = !v.ddr[i] && v.port[i] && !v.pud;
    end
    if (v.twe) begin
      r.e_out[1:0] = 2'b00;
      r.e_oe[0] = v.scl; r.e_oe[1] = v.sda;
      r.e_pu[0] = v.port[0] && !v.pud; r.e_pu[1] = v.port[1] && !v.pud;
    end
    if (v.rxe) begin r.e_oe[2] = 1'b0; r.e_pu[2] = v.port[2] && !v.pud; end
    if (v.txe) begin r.e_out[3] = v.txd; r.e_oe[3] = 1'b1; r.e_pu[3] = 1'b0; end
    if (v.cme) r.e_out[4] = v.cmo;
    if (v.xce && v.ddr[5]) r.e_out[5] = v.xco;
    if (v.xme && v.msk < 3'd6) begin r.e_out[6] = v.adb; r.e_oe[6] = 1'b1; r.e_pu[6] = 1'b0; end
    if (v.cke) begin r.e_out[7] = v.ckd; r.e_oe[7] = 1'b1; r.e_pu[7] = 1'b0; end
    return r;
  endfunction

  initial begin
    #(CLK_NS * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state: R2 synchronizer cleared, R10 clock driven during reset
    pad_in = 8'hFF; clko_en = 1'b1; clk_div = 1'b1; ddr_q = 8'h00; port_q = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    check8("R2 reset sync", pin_sync, 8'h00);
    check8("R10 oe in reset", {7'd0, pad_oe[7]}, 8'h01);
    check8("R10 out in reset", {7'd0, pad_out[7]}, 8'h01);
    clko_en = 1'b0; pad_in = 8'h00;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      drive(VECS[n]);
      #1;
      check8("R1/R3-R5/R7-R10 table out", pad_out, VECS[n].e_out);
      check8("R1/R3-R5/R7-R10 table oe", pad_oe, VECS[n].e_oe);
      check8("R1/R3-R5/R7-R10 table pu", pad_pu, VECS[n].e_pu);
    end

    // sweep of override combinations against the model
    for (int n = 0; n < 600; n++) begin
      vec_t v;
      v = vec_t'({$urandom(), $urandom()});
      v = model(v);
      @(negedge clk);
      drive(v);
      #1;
      check8("R1 R3 R4 R5 R7 R8 R9 R10 sweep out", pad_out, v.e_out);
      check8("R1 R3 R4 R5 R7 R8 R9 R10 sweep oe", pad_oe, v.e_oe);
      check8("R1 R3 R4 R5 R7 R8 R9 R10 sweep pu", pad_pu, v.e_pu);
    end

    // R2 latency: new value appears after the second edge
    drive('0);
    @(negedge clk); pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'hA5;
    @(negedge clk); #1;
    check8("R2 after one edge", pin_sync, 8'h00);
    @(negedge clk); #1;
    check8("R2 after two edges", pin_sync, 8'hA5);

    // R6: gating with interrupt keep on pins 0 and 2
    in_gate_off = 1'b1; xint_en = 4'b0101; pad_in = 8'hFF;
    repeat (3) @(negedge clk); #1;
    check8("R6 gated with keep", pin_sync, 8'h05);
    xint_en = 4'b0000;
    repeat (3) @(negedge clk); #1;
    check8("R6 all gated", pin_sync, 8'h00);
    in_gate_off = 1'b0;
    repeat (3) @(negedge clk); #1;
    check8("R6 ungated", pin_sync, 8'hFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule